// File: doc/BRIEF.md
# ALU with Latched Skip-Condition Flag

This block is the arithmetic stage of a single-bus multicycle datapath. Two operand registers, A and B, capture the shared bus when their own load strobes are high. A 2-bit function code selects one of four 32-bit operations on them. The result reaches the bus only while a drive enable is high. When the drive enable is low the block presents zero together with a low output-enable, so the bus can be built as a wired-OR or a tri-state driver.

A combinational condition stage watches the bus value itself rather than the operands. During a skip-style instruction the control unit selects subtraction and drives the result onto the bus. The condition stage then reads that value as A minus B and, under a 4-bit mode code taken from the instruction, produces a single pass/fail bit. A one-bit flag register captures this bit when its load strobe is high. The control unit's sequencer uses the flag to choose its next state.

Top module: `alu_skip_unit`

## Requirements
- R1: After reset, A, B and the condition flag are zero: `cmp_o` is 0, and with function 00 and the drive enable high, `alu_bus_o` is 0.
- R2: A takes the value of `bus_i` at a rising clock edge when `ld_a_i` is high, and otherwise keeps its value.
- R3: B takes the value of `bus_i` at a rising clock edge when `ld_b_i` is high, and otherwise keeps its value.
- R4: Function code 2'b00 gives A + B, modulo 2^32.
- R5: Function code 2'b01 gives A − B, modulo 2^32.
- R6: Function code 2'b10 gives the bitwise NOT of (A AND B).
- R7: Function code 2'b11 gives A + 1, modulo 2^32. B has no effect on this result.
- R8: With `dr_alu_i` high, `alu_bus_o` carries the selected result and `alu_oe_o` is 1. With `dr_alu_i` low, `alu_bus_o` is all zeros and `alu_oe_o` is 0.
- R9: Mode code 4'h0 gives a true condition exactly when `bus_i` is all zeros.
- R10: Mode code 4'h1 gives a true condition exactly when bit 31 of `bus_i` is 1. This is a signed less-than taken from the subtraction result, with overflow ignored.
- R11: Any mode code other than 4'h0 and 4'h1 gives a false condition.
- R12: `cmp_o` takes the condition of the current bus and mode at a rising edge when `ld_cmp_i` is high, and otherwise holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| bus_i | input | 32 | Current value of the shared datapath bus |
| ld_a_i | input | 1 | Load strobe for operand A |
| ld_b_i | input | 1 | Load strobe for operand B |
| func_i | input | 2 | Operation select |
| dr_alu_i | input | 1 | Drive enable for the result onto the bus |
| mode_i | input | 4 | Condition mode taken from the instruction |
| ld_cmp_i | input | 1 | Load strobe for the condition flag |
| alu_bus_o | output | 32 | Gated result toward the bus |
| alu_oe_o | output | 1 | High while the result is being driven |
| cmp_o | output | 1 | Latched condition flag for the sequencer |

## Verification
The assertions run on every cycle and cover the output gating, the hold of the flag when its strobe is low, and the flag value each mode code must latch from the bus. The arithmetic of each function code, operand loading and hold, and the reset state can only be seen from the bench. The bench sweeps every pair drawn from a set of edge-case operands through all four functions and several modes, and compares each result with values it computes itself.

// File: rtl/alu_skip_pkg.sv
package alu_skip_pkg;
  typedef enum logic [1:0] {
    FN_ADD  = 2'b00,
    FN_SUB  = 2'b01,
    FN_NAND = 2'b10,
    FN_INC  = 2'b11
  } alu_fn_e;

  localparam int unsigned MODE_W   = 4;
  localparam logic [MODE_W-1:0] MODE_EQ = 4'h0;
  localparam logic [MODE_W-1:0] MODE_LT = 4'h1;
endpackage

// File: rtl/alu_operand_regs.sv
module alu_operand_regs #(
  parameter int unsigned WIDTH = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] bus_i,
  input  logic [1:0]       ld_i,
  output logic [WIDTH-1:0] a_o,
  output logic [WIDTH-1:0] b_o
);
  logic [WIDTH-1:0] q [2];

  for (genvar g = 0; g < 2; g++) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)      q[g] <= '0;
      else if (ld_i[g]) q[g] <= bus_i;
    end
  end

  assign a_o = q[0];
  assign b_o = q[1];
endmodule

// File: rtl/alu_core.sv
module alu_core
  import alu_skip_pkg::*;
#(
  parameter int unsigned WIDTH = 32
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic [1:0]       func_i,
  output logic [WIDTH-1:0] res_o
);
  localparam logic [WIDTH-1:0] ONE = WIDTH'(1);

  always_comb begin
    unique case (alu_fn_e'(func_i))
      FN_ADD:  res_o = a_i + b_i;
      FN_SUB:  res_o = a_i - b_i;
      FN_NAND: res_o = ~(a_i & b_i);
      FN_INC:  res_o = a_i + ONE;
      default: res_o = '0;
    endcase
  end
endmodule

// File: rtl/alu_cond_decode.sv
module alu_cond_decode
  import alu_skip_pkg::*;
#(
  parameter int unsigned WIDTH = 32
) (
  input  logic [WIDTH-1:0]  bus_i,
  input  logic [MODE_W-1:0] mode_i,
  output logic              cond_o
);
  logic is_zero, is_neg;

  assign is_zero = (bus_i == '0);
  assign is_neg  = bus_i[WIDTH-1]; // sign of A-B, overflow ignored

  always_comb begin
    case (mode_i)
      MODE_EQ: cond_o = is_zero;
      MODE_LT: cond_o = is_neg;
      default: cond_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/alu_skip_unit.sv
module alu_skip_unit
  import alu_skip_pkg::*;
#(
  parameter int unsigned WIDTH = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [WIDTH-1:0]  bus_i,
  input  logic              ld_a_i,
  input  logic              ld_b_i,
  input  logic [1:0]        func_i,
  input  logic              dr_alu_i,
  input  logic [MODE_W-1:0] mode_i,
  input  logic              ld_cmp_i,
  output logic [WIDTH-1:0]  alu_bus_o,
  output logic              alu_oe_o,
  output logic              cmp_o
);
  logic [WIDTH-1:0] op_a, op_b, alu_res;
  logic             cond;
  logic             cmp_q;

  alu_operand_regs #(.WIDTH(WIDTH)) u_regs (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .bus_i  (bus_i),
    .ld_i   ({ld_b_i, ld_a_i}),
    .a_o    (op_a),
    .b_o    (op_b)
  );

  alu_core #(.WIDTH(WIDTH)) u_core (
    .a_i    (op_a),
    .b_i    (op_b),
    .func_i (func_i),
    .res_o  (alu_res)
  );

  alu_cond_decode #(.WIDTH(WIDTH)) u_cond (
    .bus_i  (bus_i),
    .mode_i (mode_i),
    .cond_o (cond)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       cmp_q <= 1'b0;
    else if (ld_cmp_i) cmp_q <= cond;
  end

  assign alu_bus_o = dr_alu_i ? alu_res : '0;
  assign alu_oe_o  = dr_alu_i;
  assign cmp_o     = cmp_q;
endmodule

// File: rtl/alu_skip_unit_checker.sv
module alu_skip_unit_checker
  import alu_skip_pkg::*;
#(
  parameter int unsigned WIDTH = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [WIDTH-1:0]  bus_i,
  input logic              dr_alu_i,
  input logic [MODE_W-1:0] mode_i,
  input logic              ld_cmp_i,
  input logic [WIDTH-1:0]  alu_bus_o,
  input logic              alu_oe_o,
  input logic              cmp_o
);
  a_r8_gated_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !dr_alu_i |-> (alu_bus_o == '0) && !alu_oe_o);

  a_r12_flag_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ld_cmp_i |=> $stable(cmp_o));

  a_r9_eq_mode: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ld_cmp_i && mode_i == MODE_EQ) |=> (cmp_o == ($past(bus_i) == '0)));

  a_r10_lt_mode: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ld_cmp_i && mode_i == MODE_LT) |=> (cmp_o == $past(bus_i[WIDTH-1])));

  a_r11_other_mode: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ld_cmp_i && mode_i != MODE_EQ && mode_i != MODE_LT) |=> !cmp_o);
endmodule

bind alu_skip_unit alu_skip_unit_checker #(.WIDTH(WIDTH)) u_checker (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .bus_i     (bus_i),
  .dr_alu_i  (dr_alu_i),
  .mode_i    (mode_i),
  .ld_cmp_i  (ld_cmp_i),
  .alu_bus_o (alu_bus_o),
  .alu_oe_o  (alu_oe_o),
  .cmp_o     (cmp_o)
);

// File: tb/alu_skip_unit_tb_top.sv
module alu_skip_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] tb_bus = '0;
  logic        ld_a = 1'b0, ld_b = 1'b0, dr = 1'b0, ld_cmp = 1'b0;
  logic [1:0]  func = 2'b00;
  logic [3:0]  mode = 4'h0;
  logic [31:0] alu_bus;
  logic        oe, cmp;
  logic [31:0] bus;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  // bus model: ALU wins while it drives
  assign bus = oe ? alu_bus : tb_bus;

  alu_skip_unit dut_i (
    .clk_i(clk), .rst_ni(rst_n), .bus_i(bus), .ld_a_i(ld_a), .ld_b_i(ld_b),
    .func_i(func), .dr_alu_i(dr), .mode_i(mode), .ld_cmp_i(ld_cmp),
    .alu_bus_o(alu_bus), .alu_oe_o(oe), .cmp_o(cmp)
  );

  function automatic logic [31:0] pick(int i);
    case (i)
      0: return 32'h0000_0000;
      1: return 32'h0000_0001;
      2: return 32'hFFFF_FFFF;
      3: return 32'h7FFF_FFFF;
      4: return 32'h8000_0000;
      5: return 32'h0000_0005;
      6: return 32'hDEAD_BEEF;
      default: return 32'h1234_5678;
    endcase
  endfunction

  function automatic logic [31:0] model(logic [31:0] a, logic [31:0] b, int f);
    case (f)
      0: return a + b;
      1: return a - b;
      2: return ~(a & b);
      default: return a + 32'd1;
    endcase
  endfunction

  task automatic check(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic load_ab(logic [31:0] a, logic [31:0] b);
    @(negedge clk); dr = 1'b0; tb_bus = a; ld_a = 1'b1;
    @(negedge clk); ld_a = 1'b0; tb_bus = b; ld_b = 1'b1;
    @(negedge clk); ld_b = 1'b0;
  endtask

  task automatic latch_cond(logic [3:0] m);
    @(negedge clk); func = 2'b01; dr = 1'b1; mode = m; ld_cmp = 1'b1;
    @(negedge clk); ld_cmp = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    func = 2'b00; dr = 1'b1; #1;
    check(alu_bus == 32'd0, "R1 operands clear", alu_bus, 32'd0);
    check(cmp == 1'b0, "R1 flag clear", {31'd0, cmp}, 32'd0);

    for (int i = 0; i < 8; i++) begin
      for (int j = 0; j < 8; j++) begin
        logic [31:0] a, b, d;
        logic exp_c;
        a = pick(i); b = pick(j); d = a - b;
        load_ab(a, b);
        dr = 1'b1;
        for (int f = 0; f < 4; f++) begin
          func = f[1:0]; #1;
          check(alu_bus == model(a, b, f) && oe,
                (f == 0) ? "R4 add" : (f == 1) ? "R5 sub" :
                (f == 2) ? "R6 nand" : "R7 inc", alu_bus, model(a, b, f));
        end
        dr = 1'b0; #1;
        check(alu_bus == 32'd0 && !oe, "R8 gated", alu_bus, 32'd0);

        latch_cond(4'h0);
        check(cmp == (d == 32'd0), "R9 equal mode", {31'd0, cmp}, {31'd0, d == 32'd0});
        exp_c = cmp;
        // R12: flag holds while strobe low, even with another mode
        mode = 4'h1; tb_bus = d;
        @(negedge clk);
        check(cmp == exp_c, "R12 hold", {31'd0, cmp}, {31'd0, exp_c});
        latch_cond(4'h1);
        check(cmp == d[31], "R10 less mode", {31'd0, cmp}, {31'd0, d[31]});
        latch_cond((i % 2 == 0) ? 4'h2 : 4'hF);
        check(cmp == 1'b0, "R11 other mode", {31'd0, cmp}, 32'd0);
      end
    end

    // R2/R3 hold: strobes low, bus changes, operands kept
    load_ab(32'h0000_0010, 32'h0000_0003);
    tb_bus = 32'hAAAA_5555;
    @(negedge clk);
    func = 2'b01; dr = 1'b1; #1;
    check(alu_bus == 32'h0000_000D, "R2 R3 hold", alu_bus, 32'h0000_000D);
    // R3 alone: reload B only
    dr = 1'b0; tb_bus = 32'h0000_0001; ld_b = 1'b1;
    @(negedge clk); ld_b = 1'b0; dr = 1'b1; func = 2'b01; #1;
    check(alu_bus == 32'h0000_000F, "R3 load B", alu_bus, 32'h0000_000F);
    // R7: B ignored by increment
    func = 2'b11; #1;
    check(alu_bus == 32'h0000_0011, "R7 B ignored", alu_bus, 32'h0000_0011);
    // R2 alone: reload A only
    dr = 1'b0; tb_bus = 32'h0000_0100; ld_a = 1'b1;
    @(negedge clk); ld_a = 1'b0; dr = 1'b1; func = 2'b00; #1;
    check(alu_bus == 32'h0000_0101, "R2 load A", alu_bus, 32'h0000_0101);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule